// File: doc/BRIEF.md
# Bus Access Timeout Controller

This block carries one read or write at a time from a host-side request port out to an attached module bus. After it accepts a request it drives a select strobe, active low, toward the module. It then waits for the module to pull its acknowledge low. A cycle counter runs for as long as the access is outstanding. The length of the allowed wait is chosen from two inputs: a timeout-select bit and a bus clock-rate select.

When the module acknowledges in time, the access completes normally and read data is returned to the host. When no acknowledge arrives within the chosen limit, the block declares a bus error and sets a sticky error flag. It then ends the access on its own terms. A write is dropped. A read returns a word with every bit set. The sequencer goes back to idle so the next request can be taken. A typical use is probing ports at start-up: an empty port shows up as a timed-out access.

Top module: `bus_tmo_ctrl`

## Requirements
- R1: A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. From the next cycle until completion, `req_ready` is low and `mod_sel_n` is low. During that time `mod_we` equals the request's write bit, and `mod_addr` and `mod_wdata` carry the request's address and write data.
- R2: The wait limit L is latched at acceptance from `rate_fast` and `tmo_long`. With `rate_fast`=1, L is 127 when `tmo_long`=0 and 255 when `tmo_long`=1. With `rate_fast`=0, L is 63 when `tmo_long`=0 and 127 when `tmo_long`=1.
- R3: `mod_ack_n` sampled low at the rising edge ending any of the first L cycles of `mod_sel_n` low ends the access normally. `rsp_valid` is then high for exactly one cycle, starting in the next cycle. `rsp_rdata` is the `mod_rdata` sampled at that edge for a read and zero for a write.
- R4: The cycle counter clears at acceptance and advances in each outstanding cycle without acknowledge. If no acknowledge is seen in the first L cycles, the access times out at the edge ending the L-th cycle, so `rsp_valid` rises after exactly L cycles of `mod_sel_n` low.
- R5: A read that times out completes with `rsp_rdata` all ones.
- R6: A write that times out is dropped. It completes with `rsp_valid` and `rsp_rdata` equal to zero, and nothing further happens.
- R7: `err_flag` rises in the same cycle as the `rsp_valid` of a timed-out access. It stays high through later accesses until `err_clr` is sampled high at a rising edge. A timeout in the same cycle as a clear wins.
- R8: On completion the sequencer is idle again: `req_ready` is high in the `rsp_valid` cycle and `mod_sel_n` is high, so a new request can be accepted at once.
- R9: During and right after reset, `req_ready` is high, `mod_sel_n` is high, `rsp_valid` is low and `err_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, all ones on read timeout, zero for writes |
| tmo_long | input | 1 | Selects the longer wait limit |
| rate_fast | input | 1 | 1 = fast bus clock setting, 0 = slow setting |
| err_clr | input | 1 | Clears the error flag when high |
| err_flag | output | 1 | Sticky bus error status |
| mod_sel_n | output | 1 | Module access strobe, active low |
| mod_we | output | 1 | Module write enable |
| mod_addr | output | ADDR_W | Module address |
| mod_wdata | output | DATA_W | Module write data |
| mod_rdata | input | DATA_W | Module read data |
| mod_ack_n | input | 1 | Module acknowledge, active low |

## Verification
The bench builds the block with its default parameters: 8-bit counter, 16-bit data, 8-bit address, rate selection enabled, and limits of 127, 255, 63 and 127. All four limits are therefore reachable within a short run. For each limit, a directed acknowledge at cycle L passes and one at cycle L+1 times out. Random traffic mixes reads and writes, rate and select settings, acknowledge delays and missing acknowledges, with occasional flag clears. This exercises the sticky flag, the all-ones read, the dropped write and the exact completion latency.

// File: rtl/bus_tmo_pkg.sv
package bus_tmo_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } seq_st_t;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/bus_tmo_limit.sv
module bus_tmo_limit #(
   parameter int CNT_W         = 8,
   parameter bit RATE_SEL_EN   = 1'b1,
   parameter int LIM_FAST_BASE = 127,
   parameter int LIM_FAST_EXT  = 255,
   parameter int LIM_SLOW_BASE = 63,
   parameter int LIM_SLOW_EXT  = 127
) (
   input  logic             tmo_long,
   input  logic             rate_fast,
   output logic [CNT_W-1:0] limit
);

   localparam logic [CNT_W-1:0] FB = CNT_W'(LIM_FAST_BASE);
   localparam logic [CNT_W-1:0] FE = CNT_W'(LIM_FAST_EXT);
   localparam logic [CNT_W-1:0] SB = CNT_W'(LIM_SLOW_BASE);
   localparam logic [CNT_W-1:0] SE = CNT_W'(LIM_SLOW_EXT);

   generate
      if (RATE_SEL_EN) begin : g_rate_sel
         always_comb begin
            unique case ({rate_fast, tmo_long})
               2'b11:   limit = FE;
               2'b10:   limit = FB;
               2'b01:   limit = SE;
               default: limit = SB;
            endcase
         end
      end else begin : g_fast_only
         logic rate_unused;
         assign rate_unused = rate_fast;
         assign limit = tmo_long ? FE : FB;
      end
   endgenerate

endmodule

// File: rtl/bus_tmo_counter.sv
module bus_tmo_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] limit_in,
   input  logic             run,
   input  logic             ack_seen,
   output logic             at_last
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '1;
      end else if (load) begin
         cnt_q <= '0;
         lim_q <= limit_in;
      end else if (run && !ack_seen && !at_last) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign at_last = (cnt_q == lim_q - ONE);

   // R4: counter restarts from zero on each accepted access
   a_r4_cnt_clear : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == '0));

   // R4: count never passes the limit while outstanding
   a_r4_cnt_below_lim : assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < lim_q));

   // R2: latched limit holds for the whole access
   a_r2_lim_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load) |=> $stable(lim_q));

endmodule

// File: rtl/bus_tmo_seq.sv
module bus_tmo_seq
   import bus_tmo_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mod_sel_n,
   output logic              mod_we,
   output logic [ADDR_W-1:0] mod_addr,
   output logic [DATA_W-1:0] mod_wdata,
   input  logic [DATA_W-1:0] mod_rdata,
   input  logic              mod_ack_n,
   input  logic              at_last,
   output logic              accept,
   output logic              busy,
   output logic              tmo_fire
);

   seq_st_t           st_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              rsp_v_q;
   logic [DATA_W-1:0] rsp_d_q;

   assign req_ready = (st_q == ST_IDLE);
   assign busy      = (st_q == ST_BUSY);
   assign accept    = req_ready && req_valid;
   assign tmo_fire  = busy && mod_ack_n && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rsp_v_q <= 1'b0;
         rsp_d_q <= '0;
      end else begin
         rsp_v_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  st_q    <= ST_BUSY;
                  wr_q    <= req_write;
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
               end
            end
            ST_BUSY: begin
               if (!mod_ack_n) begin
                  st_q    <= ST_IDLE;
                  rsp_v_q <= 1'b1;
                  rsp_d_q <= wr_q ? '0 : mod_rdata;
               end else if (at_last) begin
                  st_q    <= ST_IDLE;
                  rsp_v_q <= 1'b1;
                  rsp_d_q <= wr_q ? '0 : '1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_valid = rsp_v_q;
   assign rsp_rdata = rsp_d_q;
   assign mod_sel_n = !busy;
   assign mod_we    = wr_q;
   assign mod_addr  = addr_q;
   assign mod_wdata = wdata_q;

   // R3: completion is a single-cycle pulse
   a_r3_rsp_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_v_q |=> !rsp_v_q);

   // R5: timed-out read returns all ones
   a_r5_read_ones : assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_fire && !wr_q) |=> (rsp_v_q && (rsp_d_q == '1)));

   // R6: timed-out write completes with zero data
   a_r6_write_drop : assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_fire && wr_q) |=> (rsp_v_q && (rsp_d_q == '0)));

   // R8: completion leaves the sequencer idle
   a_r8_idle_on_rsp : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_v_q |-> (req_ready && mod_sel_n));

   // R1: request fields stay put while outstanding
   a_r1_fields_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(addr_q) && $stable(wdata_q) && $stable(wr_q)));

endmodule

// File: rtl/bus_tmo_errflag.sv
module bus_tmo_errflag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   logic err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   err_q <= 1'b0;
      else if (set) err_q <= 1'b1;
      else if (clr) err_q <= 1'b0;
   end

   assign flag = err_q;

   // R7: flag rises only after a timeout
   a_r7_rise_on_tmo : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(set));

   // R7: flag is sticky until cleared
   a_r7_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !clr) |=> err_q);

   // R7: timeout wins over a simultaneous clear
   a_r7_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      set |=> err_q);

endmodule

// File: rtl/bus_tmo_ctrl.sv
module bus_tmo_ctrl
   import bus_tmo_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 16,
   parameter int CNT_W         = 8,
   parameter bit RATE_SEL_EN   = 1'b1,
   parameter int LIM_FAST_BASE = 127,
   parameter int LIM_FAST_EXT  = 255,
   parameter int LIM_SLOW_BASE = 63,
   parameter int LIM_SLOW_EXT  = 127
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              tmo_long,
   input  logic              rate_fast,
   input  logic              err_clr,
   output logic              err_flag,
   output logic              mod_sel_n,
   output logic              mod_we,
   output logic [ADDR_W-1:0] mod_addr,
   output logic [DATA_W-1:0] mod_wdata,
   input  logic [DATA_W-1:0] mod_rdata,
   input  logic              mod_ack_n
);

   localparam int LIM_MAX = max4(LIM_FAST_BASE, LIM_FAST_EXT, LIM_SLOW_BASE, LIM_SLOW_EXT);

   initial begin
      assert (ADDR_W >= 1 && DATA_W >= 1) else $error("address and data widths must be positive");
      assert (CNT_W >= 2 && CNT_W <= 24) else $error("counter width out of range");
      assert (LIM_MAX <= (1 << CNT_W) - 1) else $error("limit does not fit the counter");
      assert (LIM_FAST_BASE >= 2 && LIM_FAST_EXT >= 2 && LIM_SLOW_BASE >= 2 && LIM_SLOW_EXT >= 2)
         else $error("each limit must be at least two cycles");
   end

   logic [CNT_W-1:0] limit_w;
   logic             accept_w;
   logic             busy_w;
   logic             at_last_w;
   logic             tmo_fire_w;

   bus_tmo_limit #(
      .CNT_W         (CNT_W),
      .RATE_SEL_EN   (RATE_SEL_EN),
      .LIM_FAST_BASE (LIM_FAST_BASE),
      .LIM_FAST_EXT  (LIM_FAST_EXT),
      .LIM_SLOW_BASE (LIM_SLOW_BASE),
      .LIM_SLOW_EXT  (LIM_SLOW_EXT)
   ) limit_i (
      .tmo_long  (tmo_long),
      .rate_fast (rate_fast),
      .limit     (limit_w)
   );

   bus_tmo_counter #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept_w),
      .limit_in (limit_w),
      .run      (busy_w),
      .ack_seen (!mod_ack_n),
      .at_last  (at_last_w)
   );

   bus_tmo_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_ready (req_ready),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .mod_sel_n (mod_sel_n),
      .mod_we    (mod_we),
      .mod_addr  (mod_addr),
      .mod_wdata (mod_wdata),
      .mod_rdata (mod_rdata),
      .mod_ack_n (mod_ack_n),
      .at_last   (at_last_w),
      .accept    (accept_w),
      .busy      (busy_w),
      .tmo_fire  (tmo_fire_w)
   );

   bus_tmo_errflag err_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (tmo_fire_w),
      .clr   (err_clr),
      .flag  (err_flag)
   );

   // R1: strobe and ready are never both active
   a_r1_sel_not_ready : assert property (@(posedge clk) disable iff (!rst_n)
      !mod_sel_n |-> !req_ready);

   // R7: error flag goes up together with a completion
   a_r7_err_with_rsp : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> rsp_valid);

endmodule

// File: tb/bus_tmo_ctrl_tb_top.sv
module bus_tmo_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          tmo_long = 1'b0;
   logic          rate_fast = 1'b1;
   logic          err_clr = 1'b0;
   logic          err_flag;
   logic          mod_sel_n;
   logic          mod_we;
   logic [AW-1:0] mod_addr;
   logic [DW-1:0] mod_wdata;
   logic [DW-1:0] mod_rdata = '0;
   logic          mod_ack_n = 1'b1;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;
   bit exp_err  = 1'b0;

   int          resp_delay = 0;
   int          resp_cnt   = 0;
   logic [DW-1:0] resp_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_tmo_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .tmo_long  (tmo_long),
      .rate_fast (rate_fast),
      .err_clr   (err_clr),
      .err_flag  (err_flag),
      .mod_sel_n (mod_sel_n),
      .mod_we    (mod_we),
      .mod_addr  (mod_addr),
      .mod_wdata (mod_wdata),
      .mod_rdata (mod_rdata),
      .mod_ack_n (mod_ack_n)
   );

   // module-side responder: ack goes low in the outstanding cycle numbered resp_delay (0-based)
   always @(negedge clk) begin
      if (mod_sel_n == 1'b0) begin
         if (resp_cnt == resp_delay) begin
            mod_ack_n <= 1'b0;
            mod_rdata <= resp_data;
         end
         resp_cnt <= resp_cnt + 1;
      end else begin
         resp_cnt  <= 0;
         mod_ack_n <= 1'b1;
      end
   end

   function automatic int lim_f(input bit fast, input bit lng);
      if (fast) return lng ? 255 : 127;
      return lng ? 127 : 63;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge where rsp_valid is seen
   task automatic do_access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                            input bit fast, input bit lng, input int d, input logic [DW-1:0] rd);
      int L, n, exp_n;
      bit tmo, busy_ok, fields_ok;
      logic [DW-1:0] exp_d;
      L          = lim_f(fast, lng);
      tmo        = (d > L - 1);
      exp_n      = tmo ? L + 1 : d + 2;
      exp_d      = wr ? '0 : (tmo ? '1 : rd);
      resp_delay = d;
      resp_data  = rd;
      rate_fast  = fast;
      tmo_long   = lng;
      req_write  = wr;
      req_addr   = a;
      req_wdata  = wd;
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      rate_fast = ~fast;
      tmo_long  = ~lng;
      fields_ok = (mod_we == wr) && (mod_addr == a) && (!wr || mod_wdata == wd);
      busy_ok   = 1'b1;
      n = 1;
      while (!rsp_valid && n < 600) begin
         if (req_ready !== 1'b0 || mod_sel_n !== 1'b0) busy_ok = 1'b0;
         @(negedge clk);
         n++;
      end
      exp_err = exp_err | tmo;
      check("R1 busy ready/strobe", {31'd0, busy_ok}, 32'd1);
      check("R1 module fields", {31'd0, fields_ok}, 32'd1);
      if (tmo) check("R2/R4 timeout latency", n, exp_n);
      else     check("R2/R3 ack latency", n, exp_n);
      if (tmo && !wr)     check("R5 read timeout data", rsp_rdata, exp_d);
      else if (tmo && wr) check("R6 write drop data", rsp_rdata, exp_d);
      else                check("R3 completion data", rsp_rdata, exp_d);
      check("R7 error flag", {31'd0, err_flag}, {31'd0, exp_err});
      check("R8 idle at completion", {30'd0, req_ready, mod_sel_n}, 32'd3);
   endtask

   task automatic clear_err();
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      exp_err = 1'b0;
      check("R7 clear", {31'd0, err_flag}, 32'd0);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check("R9 reset ready", {31'd0, req_ready}, 32'd1);
      check("R9 reset strobe", {31'd0, mod_sel_n}, 32'd1);
      check("R9 reset rsp", {31'd0, rsp_valid}, 32'd0);
      check("R9 reset err", {31'd0, err_flag}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 after reset", {29'd0, req_ready, mod_sel_n, err_flag}, 32'd6);

      // directed boundaries for every limit
      for (int c = 0; c < 4; c++) begin
         bit f, g;
         int L;
         f = c[1];
         g = c[0];
         L = lim_f(f, g);
         do_access(1'b0, 8'h10 + 8'(c), 16'h0, f, g, L - 1, 16'hA5C3 + 16'(c));
         do_access(1'b0, 8'h20 + 8'(c), 16'h0, f, g, L, 16'h1234);
         do_access(1'b1, 8'h30 + 8'(c), 16'hBEEF, f, g, 0, 16'h0);
         do_access(1'b1, 8'h40 + 8'(c), 16'hCAFE, f, g, 5000, 16'h0);
         clear_err();
      end

      // sticky across a good access, then clear
      do_access(1'b0, 8'h55, 16'h0, 1'b0, 1'b0, 5000, 16'h0);
      do_access(1'b0, 8'h56, 16'h0, 1'b0, 1'b0, 3, 16'h7777);
      clear_err();

      // constrained random traffic
      for (int i = 0; i < 40; i++) begin
         bit wr, f, g;
         int L, d, k;
         wr = $urandom_range(0, 1) == 1;
         f  = $urandom_range(0, 1) == 1;
         g  = $urandom_range(0, 1) == 1;
         L  = lim_f(f, g);
         k  = $urandom_range(0, 5);
         case (k)
            0: d = L - 1;
            1: d = L;
            2: d = L + $urandom_range(1, 20);
            3: d = 5000;
            default: d = $urandom_range(0, 40);
         endcase
         do_access(wr, 8'($urandom), 16'($urandom), f, g, d, 16'($urandom));
         if ($urandom_range(0, 3) == 0) clear_err();
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule